// File: doc/BRIEF.md
# TMDS Video Link Transmitter

This block produces a complete progressive video stream and drives it onto a four-lane transition-minimised serial link of the kind used by digital display inputs. With its default parameters it makes a 640 by 480 picture at 60 Hz. Each line lasts 800 pixel periods and each frame lasts 525 lines. At a 25.2 MHz pixel rate the serial bit rate is ten times that, 252 Mb/s per lane.

The block is clocked only by the bit clock. A phase counter divides that clock by ten and makes a pixel enable, so every pixel-rate register runs on the same clock with an explicit enable. A raster counter walks the horizontal and vertical positions and derives the blanking flag and both active-low sync levels. A built-in generator computes a colour pattern from the raster position and a frame count.

Each of the three colour lanes has its own encoder. In visible regions the encoder turns an 8-bit colour value into a DC-balanced 10-bit symbol. In blanking it sends a fixed control token instead, and the blue lane's token carries the two sync levels. A fourth lane carries a pixel-rate clock as a repeating 10-bit pattern. All four lanes leave through 10-bit shift registers, least significant bit first. The differential output buffers sit outside the block.

Top module: `tmds_video_tx`

## Requirements
- R1: Pixel positions count from (0,0) after reset. Horizontally a line runs active, front porch, sync, back porch (default 640/16/96/48). Vertically a frame runs the same way (default 480/10/2/33). A pixel is visible only when both positions are inside their active spans, and the first symbol sent after reset is pixel (0,0).
- R2: Horizontal sync is low only in the horizontal sync window. Vertical sync is low only on the vertical sync lines. During blanking the blue lane sends the token selected by {vsync,hsync}, written bit 9 down to bit 0: 00 gives 1101010100, 01 gives 0010101011, 10 gives 0101010100 and 11 gives 1010101011.
- R3: During blanking the green and red lanes always send 1101010100.
- R4: In a visible region, bit 8 of the symbol is 1 when XOR chaining was used and 0 when XNOR chaining was used. Bit 9 set means bits 7..0 were inverted. Decoding the symbol under this rule gives back the 8-bit colour value.
- R5: On every lane, the ones-minus-zeros total taken over the data symbols sent since the last control token stays within ±16.
- R6: The running balance clears during every control period. So the first data symbol after any control token has bit 9 equal to the inverse of bit 8.
- R7: Each lane shifts one 10-bit symbol per ten bit clocks, least significant bit first. The clock lane repeats 0000011111 (bits 0 to 4 high), and its low-to-high transition marks bit 0 of every lane's symbol.
- R8: While reset is asserted, and until the first symbol is loaded, all four lanes are driven low.
- R9: The test pattern, computed modulo 256 from pixel h, line v and frame count f, is red = 29h + 7v + 53f, green = 13h XOR 97v XOR f, blue = NOT(red XOR green).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Serial bit clock, ten times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_blue_o | output | 1 | Serial blue lane, carries sync tokens during blanking |
| lane_green_o | output | 1 | Serial green lane |
| lane_red_o | output | 1 | Serial red lane |
| lane_clk_o | output | 1 | Serial pixel-clock lane, pattern 0000011111 |

## Verification
The link is driven from its own pattern and shrunk to a small raster over several frames. Frame-dependent colours separate a correct data path from one that mixes up lanes or positions. The sync-bearing tokens show up only at the expected line and column positions, which exposes off-by-one faults in the porch boundaries. A separate encoder is swept through all 256 byte values in one unbroken run of data. That sweep covers both chaining modes, the tie case with four ones, and both inversion branches under positive and negative running balance. Control tokens placed between data runs then show whether the balance clears.

// File: rtl/tmds_tx_pkg.sv
package tmds_tx_pkg;

  localparam int SYM_W     = 10;
  localparam int COL_W     = 8;
  localparam int NUM_LANES = 3;

  // control tokens, indexed by {C1,C0}
  localparam logic [SYM_W-1:0] TOK_00 = 10'b1101010100;
  localparam logic [SYM_W-1:0] TOK_01 = 10'b0010101011;
  localparam logic [SYM_W-1:0] TOK_10 = 10'b0101010100;
  localparam logic [SYM_W-1:0] TOK_11 = 10'b1010101011;

  // clock lane pattern: five ones leave first (LSB first)
  localparam logic [SYM_W-1:0] CLK_PATTERN = 10'b0000011111;

  typedef struct packed {
    logic de;
    logic hsync_n;
    logic vsync_n;
  } vid_ctl_t;

  function automatic logic [SYM_W-1:0] ctl_token(input logic [1:0] c);
    logic [SYM_W-1:0] t;
    case (c)
      2'b00:   t = TOK_00;
      2'b01:   t = TOK_01;
      2'b10:   t = TOK_10;
      default: t = TOK_11;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import tmds_tx_pkg::*;
#(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SY  = 96,
  parameter int H_BP  = 48,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SY  = 2,
  parameter int V_BP  = 33,
  localparam int H_TOT = H_ACT + H_FP + H_SY + H_BP,
  localparam int V_TOT = V_ACT + V_FP + V_SY + V_BP,
  localparam int HW    = $clog2(H_TOT),
  localparam int VW    = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic [7:0]    frame_o,
  output vid_ctl_t      ctl_o
);

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOT - 1);
  localparam logic [HW-1:0] H_AEND  = HW'(H_ACT);
  localparam logic [VW-1:0] V_AEND  = VW'(V_ACT);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(H_ACT + H_FP + H_SY);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_ACT + V_FP + V_SY);

  logic [HW-1:0] h_q, h_nxt;
  logic [VW-1:0] v_q, v_nxt;
  logic [7:0]    f_q, f_nxt;

  always_comb begin
    h_nxt = h_q;
    v_nxt = v_q;
    f_nxt = f_q;
    if (pix_en) begin
      if (h_q == H_LAST) begin
        h_nxt = '0;
        if (v_q == V_LAST) begin
          v_nxt = '0;
          f_nxt = f_q + 8'd1;
        end else begin
          v_nxt = v_q + VW'(1);
        end
      end else begin
        h_nxt = h_q + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
      f_q <= '0;
    end else begin
      h_q <= h_nxt;
      v_q <= v_nxt;
      f_q <= f_nxt;
    end
  end

  assign hcnt_o        = h_q;
  assign vcnt_o        = v_q;
  assign frame_o       = f_q;
  assign ctl_o.de      = (h_q < H_AEND) && (v_q < V_AEND);
  assign ctl_o.hsync_n = !((h_q >= HS_BEG) && (h_q < HS_END));
  assign ctl_o.vsync_n = !((v_q >= VS_BEG) && (v_q < VS_END));

  // R1
  hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q <= H_LAST) && (v_q <= V_LAST));

  // R1
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_en && (h_q == H_LAST)) |=> $stable(v_q));

  // R2
  sync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_o.hsync_n || !ctl_o.vsync_n) |-> !ctl_o.de);

endmodule

// File: rtl/test_pattern_src.sv
module test_pattern_src
  import tmds_tx_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic [HW-1:0]    hcnt,
  input  logic [VW-1:0]    vcnt,
  input  logic [7:0]       frame,
  output logic [COL_W-1:0] red_o,
  output logic [COL_W-1:0] green_o,
  output logic [COL_W-1:0] blue_o
);

  logic [7:0] h8, v8;

  always_comb begin
    h8      = 8'(hcnt);
    v8      = 8'(vcnt);
    red_o   = h8 * 8'd29 + v8 * 8'd7 + frame * 8'd53;
    green_o = (h8 * 8'd13) ^ (v8 * 8'd97) ^ frame;
    blue_o  = ~(red_o ^ green_o);
  end

endmodule

// File: rtl/tmds_lane_enc.sv
module tmds_lane_enc
  import tmds_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             de,
  input  logic [1:0]       ctl,
  input  logic [COL_W-1:0] din,
  output logic [SYM_W-1:0] sym_o
);

  logic [8:0]        qm;
  logic [3:0]        n1d, n1q;
  logic              use_xnor;
  logic signed [5:0] bal;
  logic signed [5:0] disp_q, disp_nxt;
  logic [SYM_W-1:0]  sym_q, sym_nxt;
  logic              de_q, de_nxt;

  // stage 1: transition minimising
  always_comb begin
    n1d = '0;
    for (int i = 0; i < COL_W; i++) n1d = n1d + {3'b000, din[i]};
    use_xnor = (n1d > 4'd4) || ((n1d == 4'd4) && !din[0]);
    qm[0] = din[0];
    for (int i = 1; i < COL_W; i++)
      qm[i] = use_xnor ? ~(qm[i-1] ^ din[i]) : (qm[i-1] ^ din[i]);
    qm[8] = ~use_xnor;
    n1q = '0;
    for (int i = 0; i < COL_W; i++) n1q = n1q + {3'b000, qm[i]};
    bal = $signed({1'b0, n1q, 1'b0}) - 6'sd8;
  end

  // stage 2: DC balancing
  always_comb begin
    sym_nxt  = sym_q;
    disp_nxt = disp_q;
    de_nxt   = de_q;
    if (en) begin
      de_nxt = de;
      if (!de) begin
        sym_nxt  = ctl_token(ctl);
        disp_nxt = '0;
      end else if ((disp_q == 6'sd0) || (bal == 6'sd0)) begin
        sym_nxt  = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
        disp_nxt = qm[8] ? (disp_q + bal) : (disp_q - bal);
      end else if (((disp_q > 6'sd0) && (bal > 6'sd0)) ||
                   ((disp_q < 6'sd0) && (bal < 6'sd0))) begin
        sym_nxt  = {1'b1, qm[8], ~qm[7:0]};
        disp_nxt = disp_q + (qm[8] ? 6'sd2 : 6'sd0) - bal;
      end else begin
        sym_nxt  = {1'b0, qm[8], qm[7:0]};
        disp_nxt = disp_q - (qm[8] ? 6'sd0 : 6'sd2) + bal;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q  <= '0;
      disp_q <= '0;
      de_q   <= 1'b0;
    end else begin
      sym_q  <= sym_nxt;
      disp_q <= disp_nxt;
      de_q   <= de_nxt;
    end
  end

  assign sym_o = sym_q;

  // R5
  disp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_q >= -6'sd16) && (disp_q <= 6'sd16));

  // R6
  first_data_neutral_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && de && !de_q) |=> (sym_q[9] != sym_q[8]));

endmodule

// File: rtl/lane_serializer.sv
module lane_serializer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] sym,
  output logic         bit_o
);

  logic [W-1:0] sh_q, sh_nxt;

  always_comb begin
    if (load) sh_nxt = sym;
    else      sh_nxt = {1'b0, sh_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign bit_o = sh_q[0];

endmodule

// File: rtl/tmds_video_tx.sv
module tmds_video_tx
  import tmds_tx_pkg::*;
#(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SY  = 96,
  parameter int H_BP  = 48,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SY  = 2,
  parameter int V_BP  = 33
) (
  input  logic clk_bit,
  input  logic rst_n,
  output logic lane_blue_o,
  output logic lane_green_o,
  output logic lane_red_o,
  output logic lane_clk_o
);

  localparam int HW   = $clog2(H_ACT + H_FP + H_SY + H_BP);
  localparam int VW   = $clog2(V_ACT + V_FP + V_SY + V_BP);
  localparam int PH_W = $clog2(SYM_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // pixel enable from a divide-by-ten phase counter
  logic [PH_W-1:0] phase_q, phase_nxt;
  logic            pix_en;
  logic            enc_vld_q, enc_vld_nxt;
  logic            ser_load;

  assign pix_en = (phase_q == PH_LAST);

  always_comb begin
    phase_nxt   = pix_en ? '0 : phase_q + PH_W'(1);
    enc_vld_nxt = enc_vld_q | pix_en;
  end

  always_ff @(posedge clk_bit or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q   <= '0;
      enc_vld_q <= 1'b0;
    end else begin
      phase_q   <= phase_nxt;
      enc_vld_q <= enc_vld_nxt;
    end
  end

  // serializers wait until the encoders hold a real symbol
  assign ser_load = pix_en & enc_vld_q;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [7:0]    frame;
  vid_ctl_t      vid;

  vid_timing_gen #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SY(H_SY), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SY(V_SY), .V_BP(V_BP)
  ) u_timing (
    .clk    (clk_bit),
    .rst_n  (rst_int_n),
    .pix_en (pix_en),
    .hcnt_o (hcnt),
    .vcnt_o (vcnt),
    .frame_o(frame),
    .ctl_o  (vid)
  );

  // lane 0 blue, 1 green, 2 red
  logic [NUM_LANES-1:0][COL_W-1:0] col;
  logic [NUM_LANES-1:0][SYM_W-1:0] sym;
  logic [NUM_LANES-1:0]            ser_bit;

  test_pattern_src #(.HW(HW), .VW(VW)) u_pattern (
    .hcnt   (hcnt),
    .vcnt   (vcnt),
    .frame  (frame),
    .red_o  (col[2]),
    .green_o(col[1]),
    .blue_o (col[0])
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [1:0] ctl_g;
    if (g == 0) begin : g_sync
      assign ctl_g = {vid.vsync_n, vid.hsync_n};
    end else begin : g_nosync
      assign ctl_g = 2'b00;
    end

    tmds_lane_enc u_enc (
      .clk  (clk_bit),
      .rst_n(rst_int_n),
      .en   (pix_en),
      .de   (vid.de),
      .ctl  (ctl_g),
      .din  (col[g]),
      .sym_o(sym[g])
    );

    lane_serializer #(.W(SYM_W)) u_ser (
      .clk  (clk_bit),
      .rst_n(rst_int_n),
      .load (ser_load),
      .sym  (sym[g]),
      .bit_o(ser_bit[g])
    );
  end

  lane_serializer #(.W(SYM_W)) u_clk_ser (
    .clk  (clk_bit),
    .rst_n(rst_int_n),
    .load (ser_load),
    .sym  (CLK_PATTERN),
    .bit_o(lane_clk_o)
  );

  assign lane_blue_o  = ser_bit[0];
  assign lane_green_o = ser_bit[1];
  assign lane_red_o   = ser_bit[2];

  // R7
  clk_lane_load_chk: assert property (@(posedge clk_bit) disable iff (!rst_int_n)
    ser_load |=> lane_clk_o);

  // R7
  clk_lane_shape_chk: assert property (@(posedge clk_bit) disable iff (!rst_int_n)
    $fell(lane_clk_o) |-> $past(lane_clk_o, 5));

endmodule

// File: tb/tmds_video_tx_tb_top.sv
`timescale 1ns/1ps
module tmds_video_tx_tb_top;
  import tmds_tx_pkg::*;

  localparam int HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int NSYM = 3 * HT * VT;

  logic clk = 1'b0;
  logic rst_n;
  logic lane_b, lane_g, lane_r, lane_c;

  always #2.5 clk = ~clk;

  tmds_video_tx #(
    .H_ACT(HA), .H_FP(HF), .H_SY(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SY(VS), .V_BP(VB)
  ) dut_i (
    .clk_bit     (clk),
    .rst_n       (rst_n),
    .lane_blue_o (lane_b),
    .lane_green_o(lane_g),
    .lane_red_o  (lane_r),
    .lane_clk_o  (lane_c)
  );

  // stand-alone encoder for the full byte sweep
  logic       e_en, e_de;
  logic [1:0] e_ctl;
  logic [7:0] e_din;
  logic [9:0] e_sym;

  tmds_lane_enc enc_i (
    .clk(clk), .rst_n(rst_n), .en(e_en), .de(e_de),
    .ctl(e_ctl), .din(e_din), .sym_o(e_sym)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] tok_exp(input logic [1:0] c);
    case (c)
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic [7:0] dec(input logic [9:0] s);
    logic [7:0] m, d;
    m = s[9] ? ~s[7:0] : s[7:0];
    d[0] = m[0];
    for (int i = 1; i < 8; i++) d[i] = s[8] ? (m[i] ^ m[i-1]) : ~(m[i] ^ m[i-1]);
    return d;
  endfunction

  function automatic int sdisp(input logic [9:0] s);
    return 2 * $countones(s) - 10;
  endfunction

  task automatic test_reset();
    rst_n = 1'b0;
    e_en = 1'b0; e_de = 1'b0; e_ctl = 2'b00; e_din = 8'h00;
    repeat (4) @(negedge clk);
    // R8: lanes low in reset
    chk({lane_b, lane_g, lane_r, lane_c} == 4'b0, "R8 reset", {lane_b, lane_g, lane_r, lane_c}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R8: still low before the first load
    chk({lane_b, lane_g, lane_r, lane_c} == 4'b0, "R8 pre-load", {lane_b, lane_g, lane_r, lane_c}, 0);
  endtask

  task automatic test_link();
    logic [9:0] sb, sg, sr, sc;
    int db, dg, drr;
    int guard;
    guard = 0;
    while (lane_c !== 1'b1 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    chk(lane_c === 1'b1, "R7 clock lane start", lane_c, 1);
    db = 0; dg = 0; drr = 0;
    for (int k = 0; k < NSYM; k++) begin
      int h, v, f;
      bit de, hs_n, vs_n;
      logic [7:0] er, eg, eb;
      if (k > 0) @(negedge clk);
      for (int i = 0; i < 10; i++) begin
        if (i > 0) @(negedge clk);
        sb[i] = lane_b; sg[i] = lane_g; sr[i] = lane_r; sc[i] = lane_c;
      end
      h = k % HT;
      v = (k / HT) % VT;
      f = k / (HT * VT);
      de   = (h < HA) && (v < VA);
      hs_n = !((h >= HA + HF) && (h < HA + HF + HS));
      vs_n = !((v >= VA + VF) && (v < VA + VF + VS));
      // R7: clock lane pattern
      chk(sc == 10'b0000011111, "R7 clock pattern", sc, 10'b0000011111);
      if (de) begin
        // R9 pattern, R4 round trip
        er = 8'(h * 29 + v * 7 + f * 53);
        eg = 8'(h * 13) ^ 8'(v * 97) ^ 8'(f);
        eb = ~(er ^ eg);
        chk(dec(sr) == er, "R4 R9 red", dec(sr), er);
        chk(dec(sg) == eg, "R4 R9 green", dec(sg), eg);
        chk(dec(sb) == eb, "R4 R9 blue", dec(sb), eb);
        if (h == 0) begin
          // R6: balance cleared by preceding control period
          chk(sb[9] != sb[8], "R6 blue first data", sb[9:8], 1);
          chk(sr[9] != sr[8], "R6 red first data", sr[9:8], 1);
        end
        db += sdisp(sb); dg += sdisp(sg); drr += sdisp(sr);
        // R5
        chk(db >= -16 && db <= 16, "R5 blue balance", db, 16);
        chk(dg >= -16 && dg <= 16, "R5 green balance", dg, 16);
        chk(drr >= -16 && drr <= 16, "R5 red balance", drr, 16);
      end else begin
        db = 0; dg = 0; drr = 0;
        // R1 R2: sync token at its raster position
        chk(sb == tok_exp({vs_n, hs_n}), "R1 R2 blue token", sb, tok_exp({vs_n, hs_n}));
        // R3
        chk(sg == 10'b1101010100, "R3 green token", sg, 10'b1101010100);
        chk(sr == 10'b1101010100, "R3 red token", sr, 10'b1101010100);
      end
    end
  endtask

  task automatic test_enc_sweep();
    int d;
    @(negedge clk);
    e_en = 1'b1; e_de = 1'b0; e_ctl = 2'b00;
    @(negedge clk);
    chk(e_sym == 10'b1101010100, "R2 token 00", e_sym, 10'b1101010100);
    d = 0;
    for (int x = 0; x < 256; x++) begin
      e_de = 1'b1; e_din = 8'(x);
      @(negedge clk);
      // R4
      chk(dec(e_sym) == 8'(x), "R4 sweep decode", dec(e_sym), x);
      if (x == 0) chk(e_sym[9] != e_sym[8], "R6 sweep first", e_sym[9:8], 1);
      d += sdisp(e_sym);
      // R5
      chk(d >= -16 && d <= 16, "R5 sweep balance", d, 16);
    end
    for (int c = 0; c < 4; c++) begin
      e_de = 1'b0; e_ctl = 2'(c);
      @(negedge clk);
      // R2
      chk(e_sym == tok_exp(2'(c)), "R2 token select", e_sym, tok_exp(2'(c)));
    end
    e_de = 1'b1; e_din = 8'h3C;
    @(negedge clk);
    // R6
    chk(e_sym[9] != e_sym[8], "R6 after control", e_sym[9:8], 1);
    chk(dec(e_sym) == 8'h3C, "R4 after control", dec(e_sym), 8'h3C);
    e_en = 1'b0;
  endtask

  initial begin
    test_reset();
    test_link();
    test_enc_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule